// File: doc/BRIEF.md
# Receive Ring Buffer Packet Writer

This block stores received frames into a circular byte buffer that software drains. For each frame offered on the request port, it first checks the room between its own write pointer and the software-owned read pointer. It then emits a stream of single-byte memory writes: a 4-byte status header, the payload taken from a byte stream, and a 4-byte trailer. When the frame is finished, the write pointer moves to the next 32-bit boundary, so every header starts word-aligned.

A frame that does not fit is discarded without touching memory. In that case the block sets a sticky overflow flag and increments a saturating missed-frame counter. A frame that is stored sets a sticky receive-done flag. Software clears both flags with a write-one-to-clear strobe. Software also moves the read pointer, and it selects a ring size of 8, 16, 32 or 64 KiB. Selecting a size puts both pointers back to zero. A buffer-empty output reports when no unread bytes remain.

Top module: `rxring_writer`

## Requirements
- R1: Free space is (read pointer − write pointer) modulo the ring size. A free value of zero means the ring is empty, and a frame offered then is always accepted.
- R2: When free space is nonzero and frame length + 8 ≥ free space, the frame is dropped. No memory write occurs, the write pointer is unchanged, `irq_ovf` is set and `missed_cnt` increments.
- R3: An accepted frame of length L produces exactly L+8 byte writes at consecutive ring addresses from the write pointer: 4 header bytes, then the L payload bytes in arrival order, then 4 trailer bytes of value 0x00.
- R4: The header bytes in address order are 0x01 (bit 0 = receive OK), 0x00, then the 16-bit value L+4 written low byte first.
- R5: After the last trailer byte, `wr_ptr` equals (old pointer + L + 8) rounded up to a multiple of 4, modulo the ring size.
- R6: Each completed accepted frame sets `irq_rx_ok`. The flag is visible in the same cycle that `frm_ready` returns high.
- R7: After reset, the size code is 0 (8192 bytes), both pointers are 0, the flags are 0, `missed_cnt` is 0 and `frm_ready` is 1.
- R8: `buf_empty` is 1 exactly when (write pointer − read pointer) modulo the ring size is 0.
- R9: Every byte address wraps modulo the ring size, so a frame may straddle the end of the ring.
- R10: `irq_rx_ok` (`irq_clr` bit 0) and `irq_ovf` (`irq_clr` bit 1) hold until their clear bit is pulsed. Each clear bit affects only its own flag, and a set in the same cycle wins over a clear.
- R11: `missed_cnt` saturates at its all-ones value.
- R12: A size write with code c selects a ring of 8192·2^c bytes and sets both pointers to 0.
- R13: `in_ready` is high only while payload is being taken. Each accepted payload byte (`in_valid && in_ready`) is written in that same cycle, and `in_ready` and `frm_ready` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| size_we | input | 1 | Ring size write strobe |
| size_code | input | 2 | Ring size code c, size = 8192·2^c |
| rd_we | input | 1 | Read pointer write strobe |
| rd_wdata | input | PTR_W | New read pointer |
| frm_valid | input | 1 | Frame request |
| frm_len | input | LEN_W | Payload length of the requested frame |
| frm_ready | output | 1 | Sequencer idle, request taken |
| in_valid | input | 1 | Payload byte valid |
| in_data | input | 8 | Payload byte |
| in_ready | output | 1 | Payload byte accepted |
| mem_we | output | 1 | Byte write strobe |
| mem_addr | output | PTR_W | Byte write address |
| mem_wdata | output | 8 | Byte write data |
| wr_ptr | output | PTR_W | Current write pointer |
| buf_empty | output | 1 | No unread data in ring |
| irq_clr | input | 2 | Write-one-to-clear: bit 0 receive-OK, bit 1 overflow |
| irq_rx_ok | output | 1 | Sticky frame-stored flag |
| irq_ovf | output | 1 | Sticky frame-dropped flag |
| missed_cnt | output | MISS_W | Saturating dropped-frame count |

## Verification
A request that is taken at an edge shows its drop result (overflow flag and counter) one cycle later. An accepted request starts its header writes in that next cycle. Payload writes appear in the same cycle as the byte handshake. The receive-OK flag and the aligned write pointer appear in the cycle after the last trailer write, together with `frm_ready`.

The bench drives every input one time unit after a rising edge and samples at the falling edge. Its monitor pops each expected write in the cycle it occurs. Flag, pointer and counter checks wait for `frm_ready` to return, so each result is read in the cycle it becomes due.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_HDR  = 2'd1,
    RX_PAY  = 2'd2,
    RX_TRL  = 2'd3
  } rxr_state_e;

  // ring size = 2^(base_log2 + code); return size - 1
  function automatic logic [31:0] ring_mask_f(input int base_log2, input logic [1:0] code);
    ring_mask_f = (32'd1 << (base_log2 + int'(code))) - 32'd1;
  endfunction
endpackage

// File: rtl/rxr_space.sv
module rxr_space #(
  parameter int PTR_W = 16,
  parameter int LEN_W = 16
) (
  input  logic [PTR_W-1:0] ring_mask,
  input  logic [PTR_W-1:0] wr_ptr,
  input  logic [PTR_W-1:0] rd_ptr,
  input  logic [LEN_W-1:0] frm_len,
  output logic             empty,
  output logic             drop
);
  localparam int CW = ((LEN_W > PTR_W) ? LEN_W : PTR_W) + 1;

  logic [PTR_W-1:0] free_sp;
  logic [PTR_W-1:0] unread;
  logic [CW-1:0]    need;
  logic [CW-1:0]    room;

  always_comb begin
    free_sp = (rd_ptr - wr_ptr) & ring_mask;
    unread  = (wr_ptr - rd_ptr) & ring_mask;
    empty   = (unread == '0);
    need    = CW'(frm_len) + CW'(8);
    room    = CW'(free_sp);
    drop    = (free_sp != '0) && (need >= room);
  end
endmodule

// File: rtl/rxr_seq.sv
module rxr_seq
  import rxr_pkg::*;
#(
  parameter int PTR_W = 16,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PTR_W-1:0] ring_mask,
  input  logic             ptr_clr,
  input  logic             frm_valid,
  input  logic [LEN_W-1:0] frm_len,
  input  logic             drop,
  output logic             frm_ready,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  output logic             in_ready,
  output logic             mem_we,
  output logic [PTR_W-1:0] mem_addr,
  output logic [7:0]       mem_wdata,
  output logic [PTR_W-1:0] wr_ptr,
  output logic             done,
  output logic             drop_evt
);
  rxr_state_e       st_q, st_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic [PTR_W-1:0] wr_q, wr_d;
  logic [PTR_W-1:0] step;
  logic [PTR_W-1:0] plus4;
  logic [PTR_W-1:0] aligned;
  logic [15:0]      hlen;
  logic [7:0]       hdr_byte;

  always_comb begin
    hlen = 16'(len_q) + 16'd4;
    case (cnt_q[1:0])
      2'd0:    hdr_byte = 8'h01;
      2'd1:    hdr_byte = 8'h00;
      2'd2:    hdr_byte = hlen[7:0];
      default: hdr_byte = hlen[15:8];
    endcase
    step    = (wr_q + PTR_W'(1)) & ring_mask;
    plus4   = wr_q + PTR_W'(4);
    aligned = {plus4[PTR_W-1:2], 2'b00} & ring_mask;
  end

  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    len_d     = len_q;
    wr_d      = wr_q;
    done      = 1'b0;
    drop_evt  = 1'b0;
    mem_we    = 1'b0;
    mem_wdata = 8'h00;
    frm_ready = (st_q == RX_IDLE);
    in_ready  = (st_q == RX_PAY);
    case (st_q)
      RX_IDLE: begin
        if (frm_valid) begin
          if (drop) begin
            drop_evt = 1'b1;
          end else begin
            len_d = frm_len;
            cnt_d = '0;
            st_d  = RX_HDR;
          end
        end
      end
      RX_HDR: begin
        mem_we    = 1'b1;
        mem_wdata = hdr_byte;
        wr_d      = step;
        cnt_d     = cnt_q + LEN_W'(1);
        if (cnt_q == LEN_W'(3)) begin
          cnt_d = '0;
          st_d  = (len_q == '0) ? RX_TRL : RX_PAY;
        end
      end
      RX_PAY: begin
        if (in_valid) begin
          mem_we    = 1'b1;
          mem_wdata = in_data;
          wr_d      = step;
          cnt_d     = cnt_q + LEN_W'(1);
          if ((cnt_q + LEN_W'(1)) == len_q) begin
            cnt_d = '0;
            st_d  = RX_TRL;
          end
        end
      end
      default: begin
        mem_we = 1'b1;
        wr_d   = step;
        cnt_d  = cnt_q + LEN_W'(1);
        if (cnt_q == LEN_W'(3)) begin
          cnt_d = '0;
          wr_d  = aligned;
          done  = 1'b1;
          st_d  = RX_IDLE;
        end
      end
    endcase
    if (ptr_clr) wr_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= RX_IDLE;
      cnt_q <= '0;
      len_q <= '0;
      wr_q  <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      len_q <= len_d;
      wr_q  <= wr_d;
    end
  end

  assign mem_addr = wr_q;
  assign wr_ptr   = wr_q;
endmodule

// File: rtl/rxr_flags.sv
module rxr_flags #(
  parameter int MISS_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic              drop_evt,
  input  logic [1:0]        irq_clr,
  output logic              irq_rx_ok,
  output logic              irq_ovf,
  output logic [MISS_W-1:0] missed_cnt
);
  logic              ok_q, ok_d;
  logic              ovf_q, ovf_d;
  logic [MISS_W-1:0] miss_q, miss_d;

  always_comb begin
    ok_d   = (ok_q & ~irq_clr[0]) | done;
    ovf_d  = (ovf_q & ~irq_clr[1]) | drop_evt;
    miss_d = miss_q;
    if (drop_evt && (miss_q != '1)) miss_d = miss_q + MISS_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok_q   <= 1'b0;
      ovf_q  <= 1'b0;
      miss_q <= '0;
    end else begin
      ok_q   <= ok_d;
      ovf_q  <= ovf_d;
      miss_q <= miss_d;
    end
  end

  assign irq_rx_ok  = ok_q;
  assign irq_ovf    = ovf_q;
  assign missed_cnt = miss_q;
endmodule

// File: rtl/rxring_writer.sv
module rxring_writer
  import rxr_pkg::*;
#(
  parameter int PTR_W    = 16,
  parameter int LEN_W    = 16,
  parameter int MISS_W   = 16,
  parameter int MIN_LOG2 = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              size_we,
  input  logic [1:0]        size_code,
  input  logic              rd_we,
  input  logic [PTR_W-1:0]  rd_wdata,
  input  logic              frm_valid,
  input  logic [LEN_W-1:0]  frm_len,
  output logic              frm_ready,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  output logic              in_ready,
  output logic              mem_we,
  output logic [PTR_W-1:0]  mem_addr,
  output logic [7:0]        mem_wdata,
  output logic [PTR_W-1:0]  wr_ptr,
  output logic              buf_empty,
  input  logic [1:0]        irq_clr,
  output logic              irq_rx_ok,
  output logic              irq_ovf,
  output logic [MISS_W-1:0] missed_cnt
);
  logic [1:0]       size_q, size_d;
  logic [PTR_W-1:0] rd_q, rd_d;
  logic [PTR_W-1:0] ring_mask;
  logic             drop;
  logic             done;
  logic             drop_evt;

  always_comb begin
    size_d = size_q;
    rd_d   = rd_q;
    if (rd_we) rd_d = rd_wdata;
    if (size_we) begin
      size_d = size_code;
      rd_d   = '0;
    end
    ring_mask = PTR_W'(ring_mask_f(MIN_LOG2, size_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q <= 2'd0;
      rd_q   <= '0;
    end else begin
      size_q <= size_d;
      rd_q   <= rd_d;
    end
  end

  rxr_space #(.PTR_W(PTR_W), .LEN_W(LEN_W)) u_space (
    .ring_mask (ring_mask),
    .wr_ptr    (wr_ptr),
    .rd_ptr    (rd_q),
    .frm_len   (frm_len),
    .empty     (buf_empty),
    .drop      (drop)
  );

  rxr_seq #(.PTR_W(PTR_W), .LEN_W(LEN_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .ring_mask (ring_mask),
    .ptr_clr   (size_we),
    .frm_valid (frm_valid),
    .frm_len   (frm_len),
    .drop      (drop),
    .frm_ready (frm_ready),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_ready  (in_ready),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .wr_ptr    (wr_ptr),
    .done      (done),
    .drop_evt  (drop_evt)
  );

  rxr_flags #(.MISS_W(MISS_W)) u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .done       (done),
    .drop_evt   (drop_evt),
    .irq_clr    (irq_clr),
    .irq_rx_ok  (irq_rx_ok),
    .irq_ovf    (irq_ovf),
    .missed_cnt (missed_cnt)
  );
endmodule

// File: rtl/rxr_chk.sv
module rxr_chk #(
  parameter int PTR_W  = 16,
  parameter int MISS_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frm_valid,
  input logic              frm_ready,
  input logic              in_valid,
  input logic [7:0]        in_data,
  input logic              in_ready,
  input logic              mem_we,
  input logic [PTR_W-1:0]  mem_addr,
  input logic [7:0]        mem_wdata,
  input logic [PTR_W-1:0]  wr_ptr,
  input logic              irq_ovf,
  input logic [MISS_W-1:0] missed_cnt,
  input logic [PTR_W-1:0]  ring_mask,
  input logic              drop
);
  // R9
  addr_in_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ((mem_addr & ~ring_mask) == '0));

  // R5
  wr_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frm_ready) |-> (wr_ptr[1:0] == 2'b00));

  // R2
  ovf_on_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && frm_ready && drop) |=> irq_ovf);

  // R2
  idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm_ready |-> !mem_we);

  // R13
  handshake_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({in_ready, frm_ready}));

  // R13
  pay_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && in_valid) |-> (mem_we && (mem_wdata == in_data)));

  // R11
  missed_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (missed_cnt >= $past(missed_cnt)));
endmodule

bind rxring_writer rxr_chk #(.PTR_W(PTR_W), .MISS_W(MISS_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .frm_valid  (frm_valid),
  .frm_ready  (frm_ready),
  .in_valid   (in_valid),
  .in_data    (in_data),
  .in_ready   (in_ready),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata),
  .wr_ptr     (wr_ptr),
  .irq_ovf    (irq_ovf),
  .missed_cnt (missed_cnt),
  .ring_mask  (ring_mask),
  .drop       (drop)
);

// File: tb/rxring_writer_tb.sv
`timescale 1ns/1ps
module rxring_writer_tb;
  localparam int PW = 16;
  localparam int LW = 16;
  localparam int MW = 4;

  logic clk, rst_n;
  logic size_we; logic [1:0] size_code;
  logic rd_we; logic [PW-1:0] rd_wdata;
  logic frm_valid; logic [LW-1:0] frm_len; logic frm_ready;
  logic in_valid; logic [7:0] in_data; logic in_ready;
  logic mem_we; logic [PW-1:0] mem_addr; logic [7:0] mem_wdata;
  logic [PW-1:0] wr_ptr; logic buf_empty;
  logic [1:0] irq_clr; logic irq_rx_ok, irq_ovf; logic [MW-1:0] missed_cnt;

  rxring_writer #(.PTR_W(PW), .LEN_W(LW), .MISS_W(MW)) u_dut (
    .clk(clk), .rst_n(rst_n), .size_we(size_we), .size_code(size_code),
    .rd_we(rd_we), .rd_wdata(rd_wdata), .frm_valid(frm_valid), .frm_len(frm_len),
    .frm_ready(frm_ready), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .wr_ptr(wr_ptr),
    .buf_empty(buf_empty), .irq_clr(irq_clr), .irq_rx_ok(irq_rx_ok), .irq_ovf(irq_ovf),
    .missed_cnt(missed_cnt)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  logic [23:0] exp_q[$];
  int wr_m, rd_m, mask_m, missed_m;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // monitor: pops one expected write per observed write (R3 R4 R9)
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3 unexpected write", int'(mem_addr), -1);
      end else begin
        logic [23:0] e;
        e = exp_q.pop_front();
        chk({mem_addr, mem_wdata} == e, "R3/R4/R9 write addr:data",
            int'({mem_addr, mem_wdata}), int'(e));
      end
    end
  end

  task automatic push_w(input int a, input int d);
    exp_q.push_back({16'(a & mask_m), 8'(d)});
  endtask

  task automatic send_frame(input int len, input int seed);
    int free_m; bit drop_m; int k; int a;
    free_m = (rd_m - wr_m) & mask_m;
    drop_m = (free_m != 0) && (len + 8 >= free_m);
    if (drop_m) begin
      if (missed_m < (1 << MW) - 1) missed_m++;
    end else begin
      a = wr_m;
      push_w(a, 8'h01); push_w(a + 1, 8'h00);
      push_w(a + 2, (len + 4) & 255); push_w(a + 3, ((len + 4) >> 8) & 255);
      for (int i = 0; i < len; i++) push_w(a + 4 + i, (seed + i) & 255);
      for (int i = 0; i < 4; i++) push_w(a + 4 + len + i, 0);
      wr_m = ((a + len + 8 + 3) & ~3) & mask_m;
    end
    @(posedge clk); #1;
    frm_valid = 1'b1; frm_len = LW'(len);
    @(posedge clk); #1;
    frm_valid = 1'b0;
    if (!drop_m) begin
      k = 0;
      in_valid = 1'b1;
      while (k < len) begin
        in_data = 8'(seed + k);
        if (in_ready) k++;
        @(posedge clk); #1;
      end
      in_valid = 1'b0;
    end
    @(negedge clk);
    while (!frm_ready) @(negedge clk);
    chk(exp_q.size() == 0, "R3 all writes seen", exp_q.size(), 0);
    chk(int'(wr_ptr) == wr_m, "R5 wr_ptr after frame", int'(wr_ptr), wr_m);
    chk(int'(missed_cnt) == missed_m, "R2/R11 missed_cnt", int'(missed_cnt), missed_m);
    if (drop_m) chk(irq_ovf == 1'b1, "R2 overflow flag", int'(irq_ovf), 1);
    else        chk(irq_rx_ok == 1'b1, "R6 rx ok flag", int'(irq_rx_ok), 1);
  endtask

  task automatic set_rd(input int v);
    @(posedge clk); #1; rd_we = 1'b1; rd_wdata = PW'(v);
    @(posedge clk); #1; rd_we = 1'b0;
    rd_m = v;
  endtask

  task automatic set_size(input int c);
    @(posedge clk); #1; size_we = 1'b1; size_code = 2'(c);
    @(posedge clk); #1; size_we = 1'b0;
    mask_m = (8192 << c) - 1; wr_m = 0; rd_m = 0;
  endtask

  task automatic clr_flags(input logic [1:0] b);
    @(posedge clk); #1; irq_clr = b;
    @(posedge clk); #1; irq_clr = 2'b00;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; size_we = 0; size_code = 0; rd_we = 0; rd_wdata = 0;
    frm_valid = 0; frm_len = 0; in_valid = 0; in_data = 0; irq_clr = 0;
    wr_m = 0; rd_m = 0; mask_m = 8191; missed_m = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R7 reset state
    chk(frm_ready && !in_ready && wr_ptr == 0, "R7 reset ready/ptr", int'(wr_ptr), 0);
    chk(!irq_rx_ok && !irq_ovf && missed_cnt == 0, "R7 reset flags",
        int'({irq_rx_ok, irq_ovf, missed_cnt}), 0);
    chk(buf_empty == 1'b1, "R8 empty after reset", int'(buf_empty), 1);

    send_frame(5, 8'h10);
    chk(buf_empty == 1'b0, "R8 not empty with unread data", int'(buf_empty), 0);
    repeat (3) @(negedge clk);
    chk(irq_rx_ok == 1'b1, "R10 flag sticky", int'(irq_rx_ok), 1);
    clr_flags(2'b01);
    chk(irq_rx_ok == 1'b0, "R10 clear rx ok", int'(irq_rx_ok), 0);
    set_rd(16);
    @(negedge clk);
    chk(buf_empty == 1'b1, "R8 empty after drain", int'(buf_empty), 1);

    send_frame(0, 0);                 // R4 zero-length header 0x0004
    set_rd(wr_m + 20);                // R1 free space 20
    send_frame(12, 8'h40);            // R2 12+8 >= 20: dropped
    send_frame(11, 8'h50);            // R1 19 < 20: accepted, fills to rd
    @(negedge clk);
    chk(buf_empty == 1'b1, "R8 ring full reads empty", int'(buf_empty), 1);
    send_frame(30, 8'h60);            // R1 free 0 means empty: accepted
    clr_flags(2'b10);
    chk(irq_ovf == 1'b0 && irq_rx_ok == 1'b1, "R10 per-bit clear",
        int'({irq_ovf, irq_rx_ok}), 1);

    // R9 wrap across the ring end
    for (int f = 0; f < 5; f++) begin
      set_rd(wr_m);
      send_frame(2000, f * 7);
    end
    chk(wr_m == 1932, "R9 model wrap point", wr_m, 1932);

    // R12 size change
    set_size(1);
    @(negedge clk);
    chk(wr_ptr == 0 && buf_empty, "R12 size write clears pointers", int'(wr_ptr), 0);
    set_rd(16380);
    send_frame(8186, 8'h33);          // R12 fits only in a 16 KiB ring
    chk(irq_rx_ok == 1'b1 && wr_ptr == 8196, "R12 larger ring accepted", int'(wr_ptr), 8196);

    // R11 saturation
    set_rd(wr_m + 20);
    for (int d = 0; d < 16; d++) send_frame(12, 0);
    chk(missed_cnt == 4'hF, "R11 saturated", int'(missed_cnt), 15);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule